// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four independent pulse-width-modulated outputs from a single source clock. Each channel runs two cascaded counters. A prescaler divides the source clock into ticks. A period counter advances once per tick and wraps at its own limit. The output is high while the period counter is below a high-duration compare value, so each period starts with its high phase.

Software configures a channel through a small word-addressed register bus with two 32-bit words per channel. Writes to the divider and duty fields only stage new values. A write to the control word with its commit bit set moves the staged set into the active set that drives the counters. While the channel is running, the copy waits for the next period boundary, so no period is ever cut short or stretched. While the channel is stopped, the copy happens at once. The enable bit sits in the same control word, so a single write can both commit and start a channel.

Top module: `pwm4_prescaled`

## Requirements
- R1: After reset every output is low and every register word reads back as zero.
- R2: Word address 2*i+0 holds channel i's high-duration count in bits [31:16] and its period divider in bits [15:0]. Word address 2*i+1 holds the prescale divider in bits [15:0], the commit request in bit 30 and the enable in bit 31. Read data arrives with a valid strobe on the cycle after the read. It returns the staged fields and the enable, and bit 30 always reads 0.
- R3: While enabled, one output period lasts (pre+1)*(div+1) source-clock cycles, where pre is the prescale divider and div is the period divider.
- R4: While enabled, the output is high for the first high*(pre+1) cycles of each period and low for the rest.
- R5: A high-duration of 0 gives a constant low output while enabled. Any high-duration greater than div, including div+1, gives a constant high output.
- R6: A write without the commit bit changes only the staged values. The output waveform does not change.
- R7: A commit on a running channel takes effect at the next period boundary. The first cycle that uses the new settings is the first cycle of a new period.
- R8: A disabled channel holds its output low and its counters at zero. A commit while disabled is applied at once. After enable, output starts at position 0 of a period on the cycle after the enabling write has been registered.
- R9: Writes to one channel leave the waveforms of the other channels undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for the bus and all counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address: channel in [2:1], word select in [0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held until the next read |
| bus_rvalid | output | 1 | One-cycle strobe marking read data valid |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Read data is due one clock edge after the edge that captures the read, and the bench pairs each returned word with the oldest queued expectation. The enable and commit bits are registered at the write edge and take effect on the following edge. The first affected output sample is therefore the one after that second edge, or, for a running channel, the first sample of the next period. Every expected output level is stamped with the absolute cycle in which it must be seen. The monitor compares only stamps equal to the current cycle, sampling on the falling edge. Pending stamps for several channels overlap in time, so the bench can check that channels do not disturb each other while writes go to a neighbour.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int CNT_W   = 16;   // divider and compare field width
    localparam int DATA_W  = 32;   // register word width
    localparam int EN_BIT  = 31;   // enable bit in the control word
    localparam int UPD_BIT = 30;   // commit request bit in the control word

    typedef struct packed {
        logic [CNT_W-1:0] high;    // high-duration in period ticks
        logic [CNT_W-1:0] div;     // period counter limit
        logic [CNT_W-1:0] pre;     // prescaler limit
    } pwm_cfg_t;

    typedef struct packed {
        pwm_cfg_t         act;
        logic [CNT_W-1:0] pre_cnt;
        logic [CNT_W-1:0] per_cnt;
        logic             run;
        logic             pend;
    } chan_st_t;

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int ADR_W = CH_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    output pwm_cfg_t [NUM_CH-1:0]   stg_cfg,
    output logic [NUM_CH-1:0]       en_vec,
    output logic [NUM_CH-1:0]       upd_vec
);

    typedef struct packed {
        pwm_cfg_t [NUM_CH-1:0] cfg;
        logic [NUM_CH-1:0]     en;
        logic [NUM_CH-1:0]     upd;
        logic [DATA_W-1:0]     rdata;
        logic                  rvalid;
    } regs_st_t;

    regs_st_t         st_d, st_q;
    logic [CH_W-1:0]  ch_sel;
    logic             word_sel;
    logic             unused_wbits;

    assign ch_sel   = bus_addr[ADR_W-1:1];
    assign word_sel = bus_addr[0];

    always_comb begin
        st_d         = st_q;
        st_d.upd     = '0;
        st_d.rvalid  = 1'b0;
        unused_wbits = ^bus_wdata[UPD_BIT-1:CNT_W];
        if (bus_sel && bus_wr) begin
            if (!word_sel) begin
                st_d.cfg[ch_sel].high = bus_wdata[DATA_W-1:CNT_W];
                st_d.cfg[ch_sel].div  = bus_wdata[CNT_W-1:0];
            end else begin
                st_d.cfg[ch_sel].pre  = bus_wdata[CNT_W-1:0];
                st_d.en[ch_sel]       = bus_wdata[EN_BIT];
                st_d.upd[ch_sel]      = bus_wdata[UPD_BIT];
            end
        end
        if (bus_sel && !bus_wr) begin
            st_d.rvalid = 1'b1;
            if (!word_sel) begin
                st_d.rdata = {st_q.cfg[ch_sel].high, st_q.cfg[ch_sel].div};
            end else begin
                st_d.rdata                = '0;
                st_d.rdata[EN_BIT]        = st_q.en[ch_sel];
                st_d.rdata[CNT_W-1:0]     = st_q.cfg[ch_sel].pre;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign stg_cfg    = st_q.cfg;
    assign en_vec     = st_q.en;
    assign upd_vec    = st_q.upd;

endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              upd_i,
    input  pwm_cfg_t          stg_i,
    output logic              out_o,
    output pwm_cfg_t          act_o,
    output logic [CNT_W-1:0]  pre_cnt_o,
    output logic [CNT_W-1:0]  per_cnt_o,
    output logic              pend_o
);

    chan_st_t st_d, st_q;
    logic     pend_now;
    logic     tick;
    logic     wrap;

    assign pend_now = st_q.pend | upd_i;
    assign tick     = (st_q.pre_cnt == st_q.act.pre);
    assign wrap     = tick && (st_q.per_cnt == st_q.act.div);

    always_comb begin
        st_d     = st_q;
        st_d.run = en_i;
        if (!st_q.run) begin
            // stopped: counters parked, staged set copied straight away
            st_d.pre_cnt = '0;
            st_d.per_cnt = '0;
            if (pend_now) begin
                st_d.act  = stg_i;
                st_d.pend = 1'b0;
            end
        end else begin
            if (tick) begin
                st_d.pre_cnt = '0;
                st_d.per_cnt = wrap ? '0 : st_q.per_cnt + 1'b1;
            end else begin
                st_d.pre_cnt = st_q.pre_cnt + 1'b1;
            end
            // running: copy only where one period ends and the next begins
            if (wrap && pend_now) begin
                st_d.act  = stg_i;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = pend_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o     = st_q.run && (st_q.per_cnt < st_q.act.high);
    assign act_o     = st_q.act;
    assign pre_cnt_o = st_q.pre_cnt;
    assign per_cnt_o = st_q.per_cnt;
    assign pend_o    = st_q.pend;

endmodule

// File: rtl/pwm4_prescaled.sv
module pwm4_prescaled
    import pwm4_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int ADR_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADR_W-1:0]  bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_cfg_t [NUM_CH-1:0]         stg_cfg;
    pwm_cfg_t [NUM_CH-1:0]         act_cfg;
    logic [NUM_CH-1:0]             en_vec;
    logic [NUM_CH-1:0]             upd_vec;
    logic [NUM_CH-1:0]             pend_vec;
    logic [NUM_CH-1:0][CNT_W-1:0]  act_high;
    logic [NUM_CH-1:0][CNT_W-1:0]  act_div;
    logic [NUM_CH-1:0][CNT_W-1:0]  act_pre;
    logic [NUM_CH-1:0][CNT_W-1:0]  pre_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]  per_cnt;

    pwm4_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .stg_cfg    (stg_cfg),
        .en_vec     (en_vec),
        .upd_vec    (upd_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm4_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_vec[g]),
            .upd_i     (upd_vec[g]),
            .stg_i     (stg_cfg[g]),
            .out_o     (pwm_out[g]),
            .act_o     (act_cfg[g]),
            .pre_cnt_o (pre_cnt[g]),
            .per_cnt_o (per_cnt[g]),
            .pend_o    (pend_vec[g])
        );
        assign act_high[g] = act_cfg[g].high;
        assign act_div[g]  = act_cfg[g].div;
        assign act_pre[g]  = act_cfg[g].pre;
    end

endmodule

// File: rtl/pwm4_checker.sv
module pwm4_checker
    import pwm4_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CH-1:0]              en_vec,
    input logic [NUM_CH-1:0]              upd_vec,
    input logic [NUM_CH-1:0]              pend_vec,
    input logic [NUM_CH-1:0]              pwm_out,
    input logic                           rvalid,
    input logic                           rd_upd_bit,
    input logic [NUM_CH-1:0][CNT_W-1:0]   act_high,
    input logic [NUM_CH-1:0][CNT_W-1:0]   act_div,
    input logic [NUM_CH-1:0][CNT_W-1:0]   act_pre,
    input logic [NUM_CH-1:0][CNT_W-1:0]   pre_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0]   per_cnt
);

    // commit bit never appears in read data
    p_upd_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !rd_upd_bit);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // counters stay inside the active limits
        p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_cnt[i] <= act_pre[i]) && (per_cnt[i] <= act_div[i]));

        // compare above the period limit forces a steady high
        p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_vec[i]) && (act_high[i] > act_div[i])) |-> pwm_out[i]);

        // active set moves only after a commit request
        p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(pend_vec[i]) && !$past(upd_vec[i])) |->
                ($stable(act_high[i]) && $stable(act_div[i]) && $stable(act_pre[i])));

        // a stopped channel drives low
        p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_vec[i]) |-> !pwm_out[i]);
    end

endmodule

bind pwm4_prescaled pwm4_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_vec     (en_vec),
    .upd_vec    (upd_vec),
    .pend_vec   (pend_vec),
    .pwm_out    (pwm_out),
    .rvalid     (bus_rvalid),
    .rd_upd_bit (bus_rdata[30]),
    .act_high   (act_high),
    .act_div    (act_div),
    .act_pre    (act_pre),
    .pre_cnt    (pre_cnt),
    .per_cnt    (per_cnt)
);

// File: tb/pwm4_prescaled_tb.sv
module pwm4_prescaled_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int AW         = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NUM_CH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int    at;
        int    ch;
        bit    lvl;
        string req;
    } lvl_item_t;

    typedef struct {
        logic [31:0] val;
        string       req;
    } rd_item_t;

    lvl_item_t lvl_q[$];
    rd_item_t  rd_q[$];

    pwm4_prescaled #(.NUM_CH(NUM_CH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pwm_out    (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // expected level at position pos counted from a period start
    function automatic bit wave_lvl(input int pos, input int hi, input int dv, input int pr);
        int per;
        per = (pr + 1) * (dv + 1);
        return ((pos % per) < hi * (pr + 1));
    endfunction

    // monitor: reads in order, levels by cycle stamp
    always @(negedge clk) begin
        rd_item_t ri;
        if (bus_rvalid) begin
            checks++;
            if (rd_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                ri = rd_q.pop_front();
                if (bus_rdata !== ri.val) begin
                    errors++;
                    $display("FAIL %s read actual=%h expected=%h", ri.req, bus_rdata, ri.val);
                end
            end
        end
        for (int i = lvl_q.size() - 1; i >= 0; i--) begin
            if (lvl_q[i].at == cyc) begin
                checks++;
                if (pwm_out[lvl_q[i].ch] !== lvl_q[i].lvl) begin
                    errors++;
                    $display("FAIL %s ch%0d cycle %0d actual=%b expected=%b", lvl_q[i].req,
                             lvl_q[i].ch, cyc, pwm_out[lvl_q[i].ch], lvl_q[i].lvl);
                end
                lvl_q.delete(i);
            end
        end
    end

    task automatic wr(input int ch, input int w, input logic [31:0] data);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = AW'(ch * 2 + w);
        bus_wdata = data;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int ch, input int w, input logic [31:0] exp, input string req);
        rd_item_t it;
        @(negedge clk);
        it.val = exp;
        it.req = req;
        rd_q.push_back(it);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = AW'(ch * 2 + w);
        @(negedge clk);
        bus_sel  = 1'b0;
    endtask

    task automatic push_wave(input int ch, input int start, input int n,
                             input int hi, input int dv, input int pr, input string req);
        lvl_item_t it;
        for (int k = 0; k < n; k++) begin
            it.at  = start + k;
            it.ch  = ch;
            it.lvl = wave_lvl(k, hi, dv, pr);
            it.req = req;
            lvl_q.push_back(it);
        end
    endtask

    task automatic drain();
        while (lvl_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        int now;
        int cn;
        lvl_item_t it;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        checks++;
        if (pwm_out !== '0) begin
            errors++;
            $display("FAIL R1 outputs after reset actual=%b expected=0000", pwm_out);
        end
        rd(0, 0, 32'h0000_0000, "R1");
        rd(3, 1, 32'h0000_0000, "R1");

        // R3 R4: ch0 period 10, high 4
        wr(0, 0, {16'd2, 16'd4});
        wr(0, 1, 32'hC000_0001);
        s0 = cyc + 1;
        push_wave(0, s0, 120, 2, 4, 1, "R3 R4");
        rd(0, 1, 32'h8000_0001, "R2");
        rd(0, 0, 32'h0002_0004, "R2");

        // R5: zero duty, over-range duty, div+1 duty; R9 ch0 keeps running meanwhile
        wr(1, 0, {16'd0, 16'd3});
        wr(1, 1, 32'hC000_0000);
        push_wave(1, cyc + 1, 30, 0, 3, 0, "R5");
        wr(2, 0, {16'd6, 16'd5});
        wr(2, 1, 32'hC000_0002);
        push_wave(2, cyc + 1, 30, 6, 5, 2, "R5");
        wr(3, 0, {16'd9, 16'd5});
        wr(3, 1, 32'hC000_0000);
        push_wave(3, cyc + 1, 30, 9, 5, 0, "R5 R9");

        // R6: staging without commit leaves ch0 waveform alone
        wr(0, 0, {16'd1, 16'd2});
        rd(0, 0, 32'h0001_0002, "R6");
        drain();

        // R7: commit on running ch0 lands at the next boundary
        wr(0, 1, 32'hC000_0000);
        now = cyc;
        cn  = now + 1;
        while (((cn - s0) % 10) != 0) cn++;
        for (int c = now + 1; c < cn + 30; c++) begin
            it.at  = c;
            it.ch  = 0;
            it.lvl = (c < cn) ? wave_lvl(c - s0, 2, 4, 1) : wave_lvl(c - cn, 1, 2, 0);
            it.req = "R7";
            lvl_q.push_back(it);
        end
        drain();

        // R8: disable ch2, commit while stopped, then enable without commit
        wr(2, 1, 32'h0000_0002);
        push_wave(2, cyc + 1, 6, 0, 1, 0, "R8");
        push_wave(3, cyc + 1, 20, 9, 5, 0, "R9");
        wr(2, 0, {16'd1, 16'd1});
        wr(2, 1, 32'h4000_0000);
        wr(2, 1, 32'h8000_0000);
        push_wave(2, cyc + 1, 20, 1, 1, 0, "R8");
        rd(2, 1, 32'h8000_0000, "R2");
        drain();

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule